// File: doc/BRIEF.md
# Per-Port Access Fault Recorder

This block sits beside a memory-protection checker that guards several target ports. When the checker refuses an access on a port, it pulses that port's fault strobe together with a description of the refused access. The recorder keeps one record per port. The first refusal seen on a port fills its record and raises a sticky flag. The record then stays frozen until software acknowledges it, so the details always describe the first fault since the last acknowledgement.

Software reads the flag vector and one record at a time, picked by a port select input. It acknowledges faults by writing ones to the flag bits it wants to release. A single combined output tells an interrupt controller that at least one port holds an unacknowledged fault. The fault checking itself is done elsewhere.

Top module: `port_fault_log`

## Requirements
- R1: While reset is asserted and right after it, every flag is 0, `any_fault_o` is 0 and every record field reads as 0.
- R2: A fault strobe on a port whose flag is 0 sets that flag at the next clock edge and stores the address, master, attribute, type, class and process identifier presented with the strobe.
- R3: While a port's flag is 1 and the port is not being acknowledged, further fault strobes on that port leave its record and flag unchanged.
- R4: With `ack_en_i` high, each port whose bit in `ack_mask_i` is 1 has its flag cleared at the next edge, and ports whose mask bit is 0 are unaffected. With `ack_en_i` low, `ack_mask_i` has no effect.
- R5: When an acknowledgement and a new fault strobe hit the same port in the same cycle, the new fault is stored and the flag stays 1.
- R6: `any_fault_o` is 1 exactly when at least one flag is 1.
- R7: An acknowledgement does not erase a record. The old details stay readable until the next fault on that port is captured.
- R8: Fault strobes on several ports in the same cycle are each captured in their own port's record.
- R9: Field codes are stored as given. The attribute is 0 for an instruction fetch in user mode, 1 for a data access in user mode, 2 for an instruction fetch in supervisor mode and 3 for a data access in supervisor mode. The type is 0 for a read and 1 for a write. The class is 0 for no region hit, 1 for a denial inside a single region and 2 for a denial where regions overlap.
- R10: The `rec_*_o` outputs show, without a clock delay, the stored record of the port named by `sel_port_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_vld_i | input | NP | Per-port fault strobe |
| fault_addr_i | input | NP*AW | Per-port faulting address, port p in slice p |
| fault_mst_i | input | NP*MW | Per-port master number |
| fault_attr_i | input | NP*2 | Per-port attribute code (R9) |
| fault_wr_i | input | NP | Per-port access type, 1 means write |
| fault_cls_i | input | NP*2 | Per-port fault class (R9) |
| fault_pid_i | input | NP*PW | Per-port process identifier |
| ack_en_i | input | 1 | Acknowledge write strobe |
| ack_mask_i | input | NP | Write-one-to-clear mask for the flags |
| sel_port_i | input | SW | Port whose record is shown |
| flags_o | output | NP | Sticky fault flags |
| any_fault_o | output | 1 | OR of all flags |
| rec_addr_o | output | AW | Selected record address |
| rec_mst_o | output | MW | Selected record master |
| rec_attr_o | output | 2 | Selected record attribute |
| rec_wr_o | output | 1 | Selected record type |
| rec_cls_o | output | 2 | Selected record class |
| rec_pid_o | output | PW | Selected record process identifier |

## Verification
The hardest case to reach from the ports is the one where an acknowledgement and a fresh fault land on the same port in the same cycle, while that port's record is locked. The stimulus reaches it in steps. It first fills a port, then sends a second fault to prove the lock holds, and then raises the strobe and that port's mask bit together. A long random phase follows. In that phase strobes and acknowledge masks overlap often, and the bench compares the result cycle by cycle against a behavioural model, with the port select sweeping so that every record is observed.

// File: rtl/pfl_pkg.sv
package pfl_pkg;
  localparam int unsigned ATTR_W = 2;
  localparam int unsigned CLS_W  = 2;

  typedef enum logic [ATTR_W-1:0] {
    ATTR_FETCH_USR = 2'd0,
    ATTR_DATA_USR  = 2'd1,
    ATTR_FETCH_SUP = 2'd2,
    ATTR_DATA_SUP  = 2'd3
  } attr_e;

  typedef enum logic [CLS_W-1:0] {
    CLS_NO_HIT  = 2'd0,
    CLS_SINGLE  = 2'd1,
    CLS_OVERLAP = 2'd2,
    CLS_RSVD    = 2'd3
  } cls_e;
endpackage

// File: rtl/fault_slot.sv
module fault_slot #(
  parameter int unsigned RW = 48
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hit_i,
  input  logic          clr_i,
  input  logic [RW-1:0] rec_i,
  output logic          flag_o,
  output logic [RW-1:0] rec_o
);
  logic          flag_q;
  logic [RW-1:0] rec_q;
  logic          load;

  // capture allowed when unlocked or being released this cycle
  assign load = hit_i & (~flag_q | clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      rec_q  <= '0;
    end else begin
      if (load) rec_q <= rec_i;
      flag_q <= load | (flag_q & ~clr_i);
    end
  end

  assign flag_o = flag_q;
  assign rec_o  = rec_q;
endmodule

// File: rtl/fault_rd_mux.sv
module fault_rd_mux #(
  parameter int unsigned NP = 8,
  parameter int unsigned RW = 48,
  parameter int unsigned SW = 3
) (
  input  logic [NP*RW-1:0] rec_all_i,
  input  logic [SW-1:0]    sel_i,
  output logic [RW-1:0]    rec_o
);
  always_comb begin
    rec_o = '0;
    for (int p = 0; p < NP; p++) begin
      if (SW'(p) == sel_i) rec_o = rec_all_i[p*RW +: RW];
    end
  end
endmodule

// File: rtl/port_fault_log.sv
module port_fault_log
  import pfl_pkg::*;
#(
  parameter int unsigned NP = 8,
  parameter int unsigned AW = 32,
  parameter int unsigned MW = 4,
  parameter int unsigned PW = 8,
  localparam int unsigned SW = (NP < 2) ? 1 : $clog2(NP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NP-1:0]     fault_vld_i,
  input  logic [NP*AW-1:0]  fault_addr_i,
  input  logic [NP*MW-1:0]  fault_mst_i,
  input  logic [NP*2-1:0]   fault_attr_i,
  input  logic [NP-1:0]     fault_wr_i,
  input  logic [NP*2-1:0]   fault_cls_i,
  input  logic [NP*PW-1:0]  fault_pid_i,
  input  logic              ack_en_i,
  input  logic [NP-1:0]     ack_mask_i,
  input  logic [SW-1:0]     sel_port_i,
  output logic [NP-1:0]     flags_o,
  output logic              any_fault_o,
  output logic [AW-1:0]     rec_addr_o,
  output logic [MW-1:0]     rec_mst_o,
  output logic [1:0]        rec_attr_o,
  output logic              rec_wr_o,
  output logic [1:0]        rec_cls_o,
  output logic [PW-1:0]     rec_pid_o
);
  localparam int unsigned RW = AW + MW + ATTR_W + 1 + CLS_W + PW;

  logic [NP*RW-1:0] rec_all;
  logic [RW-1:0]    rec_sel;
  logic [NP-1:0]    clr_vec;

  assign clr_vec = ack_mask_i & {NP{ack_en_i}};

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [RW-1:0] rec_in;
    assign rec_in = {fault_addr_i[p*AW +: AW], fault_mst_i[p*MW +: MW],
                     fault_attr_i[p*2 +: 2], fault_wr_i[p],
                     fault_cls_i[p*2 +: 2], fault_pid_i[p*PW +: PW]};
    fault_slot #(.RW(RW)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hit_i  (fault_vld_i[p]),
      .clr_i  (clr_vec[p]),
      .rec_i  (rec_in),
      .flag_o (flags_o[p]),
      .rec_o  (rec_all[p*RW +: RW])
    );
  end

  fault_rd_mux #(.NP(NP), .RW(RW), .SW(SW)) u_mux (
    .rec_all_i (rec_all),
    .sel_i     (sel_port_i),
    .rec_o     (rec_sel)
  );

  assign {rec_addr_o, rec_mst_o, rec_attr_o, rec_wr_o, rec_cls_o, rec_pid_o} = rec_sel;
  assign any_fault_o = |flags_o;
endmodule

// File: rtl/port_fault_log_chk.sv
module port_fault_log_chk #(
  parameter int unsigned NP = 8,
  parameter int unsigned RW = 48
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NP-1:0]    fault_vld_i,
  input logic             ack_en_i,
  input logic [NP-1:0]    ack_mask_i,
  input logic [NP-1:0]    flags_o,
  input logic             any_fault_o,
  input logic [NP*RW-1:0] rec_all
);
  assert_any_or_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_fault_o == (flags_o != '0));

  for (genvar p = 0; p < NP; p++) begin : g_chk
    assert_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_vld_i[p] |=> flags_o[p]);
    assert_rise_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flags_o[p]) |-> $past(fault_vld_i[p]));
    assert_lock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_o[p] && !(ack_en_i && ack_mask_i[p])) |=> $stable(rec_all[p*RW +: RW]));
    assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_en_i && ack_mask_i[p] && !fault_vld_i[p]) |=> !flags_o[p]);
    assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_o[p] && !(ack_en_i && ack_mask_i[p])) |=> flags_o[p]);
  end
endmodule

bind port_fault_log port_fault_log_chk #(.NP(NP), .RW(RW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fault_vld_i (fault_vld_i),
  .ack_en_i    (ack_en_i),
  .ack_mask_i  (ack_mask_i),
  .flags_o     (flags_o),
  .any_fault_o (any_fault_o),
  .rec_all     (rec_all)
);

// File: tb/port_fault_log_test.sv
module port_fault_log_test;
  localparam int NP = 8, AW = 32, MW = 4, PW = 8, SW = 3;
  localparam time PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic [NP-1:0] vld = '0, wr = '0, mask = '0;
  logic [NP*AW-1:0] addr = '0;
  logic [NP*MW-1:0] mst = '0;
  logic [NP*2-1:0] attr = '0, cls = '0;
  logic [NP*PW-1:0] pid = '0;
  logic ack_en = 0;
  logic [SW-1:0] sel = '0;
  logic [NP-1:0] flags;
  logic any;
  logic [AW-1:0] r_addr;
  logic [MW-1:0] r_mst;
  logic [1:0] r_attr, r_cls;
  logic r_wr;
  logic [PW-1:0] r_pid;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference
  bit m_flag[NP];
  logic [AW-1:0] m_addr[NP];
  logic [MW-1:0] m_mst[NP];
  logic [1:0] m_attr[NP], m_cls[NP];
  logic m_wr[NP];
  logic [PW-1:0] m_pid[NP];

  always #(PERIOD/2) clk = ~clk;

  port_fault_log #(.NP(NP), .AW(AW), .MW(MW), .PW(PW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .fault_vld_i(vld), .fault_addr_i(addr),
    .fault_mst_i(mst), .fault_attr_i(attr), .fault_wr_i(wr), .fault_cls_i(cls),
    .fault_pid_i(pid), .ack_en_i(ack_en), .ack_mask_i(mask), .sel_port_i(sel),
    .flags_o(flags), .any_fault_o(any), .rec_addr_o(r_addr), .rec_mst_o(r_mst),
    .rec_attr_o(r_attr), .rec_wr_o(r_wr), .rec_cls_o(r_cls), .rec_pid_o(r_pid));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        m_flag[p] = 0; m_addr[p] = '0; m_mst[p] = '0; m_attr[p] = '0;
        m_wr[p] = 0; m_cls[p] = '0; m_pid[p] = '0;
      end
    end else begin
      for (int p = 0; p < NP; p++) begin
        bit clr, ld;
        clr = ack_en && mask[p];
        ld = vld[p] && (!m_flag[p] || clr);
        if (ld) begin
          m_addr[p] = addr[p*AW +: AW]; m_mst[p] = mst[p*MW +: MW];
          m_attr[p] = attr[p*2 +: 2]; m_wr[p] = wr[p];
          m_cls[p] = cls[p*2 +: 2]; m_pid[p] = pid[p*PW +: PW];
          m_flag[p] = 1;
        end else if (clr) m_flag[p] = 0;
      end
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    logic [NP-1:0] ef;
    int s;
    s = int'(sel);
    for (int p = 0; p < NP; p++) ef[p] = m_flag[p];
    chk(tag, "flags", 64'(flags), 64'(ef));
    chk("R6", "any_fault", 64'(any), 64'(ef != '0));
    chk(tag, "record addr/mst", {r_addr, 28'(0), r_mst}, {m_addr[s], 28'(0), m_mst[s]});
    chk(tag, "record attr/wr/cls/pid", {r_attr, r_wr, r_cls, r_pid},
        {m_attr[s], m_wr[s], m_cls[s], m_pid[s]});
  end

  task automatic step();
    @(posedge clk); #(PERIOD/4);
  endtask

  task automatic put(int p, logic [AW-1:0] a, logic [MW-1:0] m, logic [1:0] at,
                     logic w, logic [1:0] c, logic [PW-1:0] id);
    vld[p] = 1; addr[p*AW +: AW] = a; mst[p*MW +: MW] = m;
    attr[p*2 +: 2] = at; wr[p] = w; cls[p*2 +: 2] = c; pid[p*PW +: PW] = id;
  endtask

  task automatic idle();
    vld = '0; ack_en = 0; mask = '0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    tag = "R1";
    repeat (3) step();
    rst_n = 1; step(); step();
    // R2/R9: data write in user mode, overlap class
    tag = "R2"; sel = 2;
    put(2, 32'hDEAD_BEE0, 4'd3, 2'd1, 1'b1, 2'd2, 8'h5A); step(); idle(); step();
    tag = "R9";
    put(4, 32'h0000_1234, 4'd9, 2'd2, 1'b0, 2'd0, 8'h01); sel = 4; step(); idle(); step();
    // R3: locked record
    tag = "R3"; sel = 2;
    put(2, 32'h1111_0000, 4'd7, 2'd3, 1'b0, 2'd1, 8'hFF); step(); idle(); step();
    // R4: mask without enable, enable on unrelated port
    tag = "R4";
    mask = 8'hFF; step(); idle(); step();
    ack_en = 1; mask = 8'h20; step(); idle(); step();
    // R4/R7: release port 2, record kept
    tag = "R7";
    ack_en = 1; mask = 8'h04; step(); idle(); step(); step();
    // R8: simultaneous faults
    tag = "R8";
    put(0, 32'hA000_0000, 4'd1, 2'd0, 1'b0, 2'd0, 8'h10);
    put(3, 32'hB000_0040, 4'd2, 2'd3, 1'b1, 2'd1, 8'h20);
    put(7, 32'hC000_0080, 4'd5, 2'd2, 1'b1, 2'd2, 8'h30);
    step(); idle();
    for (int s = 0; s < NP; s++) begin sel = SW'(s); step(); end
    // R5: ack and new fault same cycle on locked port 3
    tag = "R5"; sel = 3;
    ack_en = 1; mask = 8'h08;
    put(3, 32'hE000_00C0, 4'd6, 2'd1, 1'b0, 2'd2, 8'h44); step(); idle(); step();
    // R10: select sweep
    tag = "R10";
    for (int s = 0; s < NP; s++) begin sel = SW'(s); step(); end
    // random overlap of faults and acknowledgements
    tag = "R3";
    for (int i = 0; i < 2000; i++) begin
      for (int p = 0; p < NP; p++) begin
        vld[p] = ($urandom_range(0, 3) == 0);
        addr[p*AW +: AW] = $urandom; mst[p*MW +: MW] = MW'($urandom);
        attr[p*2 +: 2] = 2'($urandom); wr[p] = 1'($urandom);
        cls[p*2 +: 2] = 2'($urandom_range(0, 2)); pid[p*PW +: PW] = PW'($urandom);
      end
      ack_en = ($urandom_range(0, 2) == 0);
      mask = NP'($urandom);
      sel = SW'($urandom);
      step();
    end
    idle(); step();
    tag = "R1";
    rst_n = 0; step(); step();
    done = 1;
    summary();
  end
endmodule